// File: doc/BRIEF.md
# Programmable Pulse Train Generator

A peripheral that produces a bounded train of square pulses on one output pin. Software writes a 16-bit half-period value and a 16-bit pulse count, one byte at a time, over a simple write-only register port. It presets the resting level of the output through a level register and then sets a run bit. While the block runs, a prescaler counts down. Each time the prescaler reaches zero it reloads and the output flips. A divide-by-2 stage pairs the flips into whole pulses, and the count register steps down once for each completed pulse.

The block stops itself when the count register underflows: a pulse completes while the count is zero. It then clears its own run bit and raises a pending flag. The pending flag becomes an interrupt request only while the interrupt-enable bit is set. Software may stop the block at any time, which freezes both the count and the pin level. A new start reloads the prescaler, so the first flip after a restart always comes after a full half period. Reset clears the control bits but leaves the period and count registers as they were.

Top module: `pulse_train_gen`

## Requirements
- R1: Byte writes place data at these addresses: 0 and 1 hold the low and high bytes of the period P, 2 and 3 hold the low and high bytes of the count N, 4 is control, and 5 bit 0 is the output level. The current count is readable on cnt_o.
- R2: While running, the output flips on every (P+1)-th clock edge after the starting edge, and on no other edge.
- R3: The count register steps down by one on every second flip, which is one completed pulse.
- R4: When a pulse completes while the count is 0, the count wraps to 16'hFFFF, the run bit clears and the pending bit sets. A train started with count N therefore gives exactly 2(N+1) flips and stops on edge 2(P+1)(N+1) after the start.
- R5: irq_o is high exactly when both the pending bit and the interrupt-enable bit are set.
- R6: While the run bit is clear, the count register and the output level keep their values unless software rewrites them.
- R7: A 0-to-1 write of the run bit reloads the prescaler with P and clears the divide-by-2 stage, so the first flip after any start comes P+1 edges later.
- R8: The output begins at the level written to address 5. If the block is stopped while the output is at the opposite level, that level stays on the pin.
- R9: Control bits: bit 0 run, bit 1 interrupt enable, bit 2 pending, bit 3 test mode, all shown on ctrl_o in the same positions. Writing 0 to bit 2 clears the pending bit. Writing 1 to bit 2 has no effect. An underflow in the same cycle as a clear leaves the pending bit set.
- R10: Reset clears run, interrupt enable, pending, test mode, the divide-by-2 stage and the output level, and stops counting at once. It leaves the period and count registers unchanged.
- R11: An underflow on the same edge as a software write that clears the run bit still sets the pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Write data |
| pulse_o | output | 1 | Pulse train output |
| irq_o | output | 1 | Interrupt request |
| ctrl_o | output | 4 | Control/status bits {test, pending, ien, run} |
| cnt_o | output | 16 | Current count register |

## Verification
A table of trains is applied. The entries vary the period (0, the shortest, through 5), the count (0 through 5), the starting level and the interrupt enable. From each train the bench takes the position of every flip, the total number of flips, the stop edge and the final state. Together these tell apart an off-by-one in the prescaler reload, in the pulse pairing and in the underflow point, and show whether the resting level follows the preset. Directed sequences then stop a train at its high level, restart it, land a software stop exactly on the underflow edge, and reset the block mid-run. These separate a frozen counter from a running one, a full first pulse from a partial one, and a lost pending flag from a kept one.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  localparam int CTRL_W   = 4;
  localparam int BIT_RUN  = 0;
  localparam int BIT_IEN  = 1;
  localparam int BIT_PEND = 2;
  localparam int BIT_TEST = 3;

  typedef struct packed {
    logic test;
    logic pend;
    logic ien;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/ptg_regs.sv
module ptg_regs
  import ptg_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int PRE_BYTES = 2,
  parameter int CNT_BYTES = 2,
  localparam int PRE_W    = DATA_W * PRE_BYTES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic                 uf_i,
  output logic [PRE_W-1:0]     period_o,
  output ctrl_t                ctrl_o,
  output logic                 start_o,
  output logic [CNT_BYTES-1:0] cnt_we_o,
  output logic                 lvl_we_o
);
  localparam int CTRL_A = PRE_BYTES + CNT_BYTES;
  localparam int LVL_A  = CTRL_A + 1;

  logic [DATA_W-1:0] pre_b [PRE_BYTES];
  ctrl_t ctrl_q;
  logic  ctrl_we;

  assign ctrl_we  = wr_en_i && (wr_addr_i == ADDR_W'(CTRL_A));
  assign lvl_we_o = wr_en_i && (wr_addr_i == ADDR_W'(LVL_A));

  // period bytes: kept across reset
  for (genvar i = 0; i < PRE_BYTES; i++) begin : g_pre
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_addr_i == ADDR_W'(i))) pre_b[i] <= wr_data_i;
    end
    assign period_o[i*DATA_W +: DATA_W] = pre_b[i];
  end

  for (genvar j = 0; j < CNT_BYTES; j++) begin : g_cnt_we
    assign cnt_we_o[j] = wr_en_i && (wr_addr_i == ADDR_W'(PRE_BYTES + j));
  end

  assign start_o = ctrl_we && wr_data_i[BIT_RUN] && !ctrl_q.run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (uf_i)         ctrl_q.run <= 1'b0;
      else if (ctrl_we) ctrl_q.run <= wr_data_i[BIT_RUN];
      if (ctrl_we) begin
        ctrl_q.ien  <= wr_data_i[BIT_IEN];
        ctrl_q.test <= wr_data_i[BIT_TEST];
      end
      // underflow set outranks a software clear
      if (uf_i)                                ctrl_q.pend <= 1'b1;
      else if (ctrl_we && !wr_data_i[BIT_PEND]) ctrl_q.pend <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;

  p_uf_stops_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_i |=> !ctrl_q.run);
  p_uf_pend_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_i |=> ctrl_q.pend);
  p_pend_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.pend && !uf_i && !(ctrl_we && !wr_data_i[BIT_PEND])) |=> ctrl_q.pend);
endmodule

// File: rtl/ptg_prescaler.sv
module ptg_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             start_i,
  input  logic [PRE_W-1:0] period_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else if (start_i) begin
      pre_q <= period_i;
    end else if (run_i) begin
      if (pre_q == '0) pre_q <= period_i;
      else             pre_q <= pre_q - 1'b1;
    end
  end

  assign tick_o = run_i && (pre_q == '0);

  p_start_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (pre_q == $past(period_i)));
  p_stopped_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !start_i) |=> $stable(pre_q));
endmodule

// File: rtl/ptg_pulse.sv
module ptg_pulse #(
  parameter int DATA_W    = 8,
  parameter int CNT_BYTES = 2,
  localparam int CNT_W    = DATA_W * CNT_BYTES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  input  logic                 start_i,
  input  logic                 tick_i,
  input  logic [CNT_BYTES-1:0] cnt_we_i,
  input  logic                 lvl_we_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic                 out_o,
  output logic [CNT_W-1:0]     cnt_o,
  output logic                 uf_o
);
  logic             div_q;
  logic             out_q;
  logic             done;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign done = tick_i && div_q;
  assign uf_o = done && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= 1'b0;
    else if (start_i) div_q <= 1'b0;
    else if (tick_i)  div_q <= ~div_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       out_q <= 1'b0;
    else if (lvl_we_i) out_q <= wr_data_i[0];
    else if (tick_i)   out_q <= ~out_q;
  end

  // count register: software byte writes win over the decrement
  always_comb begin
    cnt_d = cnt_q;
    if (done) cnt_d = cnt_q - 1'b1;
    for (int b = 0; b < CNT_BYTES; b++) begin
      if (cnt_we_i[b]) cnt_d[b*DATA_W +: DATA_W] = wr_data_i;
    end
  end

  always_ff @(posedge clk_i) cnt_q <= cnt_d;

  assign out_o = out_q;
  assign cnt_o = cnt_q;

  p_freeze_cnt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && cnt_we_i == '0) |=> $stable(cnt_q));
  p_freeze_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !lvl_we_i) |=> $stable(out_q));
  p_cnt_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && cnt_we_i == '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_flip_on_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !lvl_we_i) |=> (out_q != $past(out_q)));
endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen
  import ptg_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int PRE_BYTES = 2,
  parameter int CNT_BYTES = 2,
  localparam int PRE_W    = DATA_W * PRE_BYTES,
  localparam int CNT_W    = DATA_W * CNT_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              pulse_o,
  output logic              irq_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [PRE_W-1:0]     period;
  ctrl_t                ctrl;
  logic                 start;
  logic                 tick;
  logic                 uf;
  logic                 lvl_we;
  logic [CNT_BYTES-1:0] cnt_we;

  ptg_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRE_BYTES(PRE_BYTES), .CNT_BYTES(CNT_BYTES)
  ) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .uf_i(uf), .period_o(period), .ctrl_o(ctrl), .start_o(start),
    .cnt_we_o(cnt_we), .lvl_we_o(lvl_we)
  );

  ptg_prescaler #(.PRE_W(PRE_W)) i_pre (
    .clk_i, .rst_ni, .run_i(ctrl.run), .start_i(start),
    .period_i(period), .tick_o(tick)
  );

  ptg_pulse #(.DATA_W(DATA_W), .CNT_BYTES(CNT_BYTES)) i_pulse (
    .clk_i, .rst_ni, .run_i(ctrl.run), .start_i(start), .tick_i(tick),
    .cnt_we_i(cnt_we), .lvl_we_i(lvl_we), .wr_data_i,
    .out_o(pulse_o), .cnt_o, .uf_o(uf)
  );

  assign irq_o  = ctrl.pend && ctrl.ien;
  assign ctrl_o = ctrl;

  p_irq_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (ctrl.ien && ctrl.pend));
endmodule

// File: tb/test_pulse_train_gen.sv
`timescale 1ns/1ps
module test_pulse_train_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        pulse;
  logic        irq;
  logic [3:0]  ctrl;
  logic [15:0] cnt;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pulse_train_gen i_pulse_train_gen (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .pulse_o(pulse), .irq_o(irq), .ctrl_o(ctrl), .cnt_o(cnt)
  );

  typedef struct packed {
    logic [7:0] per;
    logic [7:0] num;
    logic       lvl;
    logic       ien;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{8'd0, 8'd0, 1'b0, 1'b1},
    '{8'd1, 8'd2, 1'b1, 1'b0},
    '{8'd3, 8'd1, 1'b0, 1'b1},
    '{8'd2, 8'd4, 1'b1, 1'b1},
    '{8'd0, 8'd5, 1'b1, 1'b0},
    '{8'd5, 8'd0, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic setup(input int per, input int num, input logic lvl);
    wr(3'd0, 8'(per)); wr(3'd1, 8'h00);
    wr(3'd2, 8'(num)); wr(3'd3, 8'h00);
    wr(3'd5, {7'd0, lvl});
  endtask

  // watch a running train; t counts edges since the starting edge
  task automatic observe(input int per, output int ntog, output int nbad,
                         output int tfirst, output int tstop);
    logic prev;
    int t;
    prev = pulse; t = 0; ntog = 0; nbad = 0; tfirst = 0; tstop = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      t++;
      if (pulse !== prev) begin
        ntog++;
        if (tfirst == 0) tfirst = t;
        if (t % (per + 1) != 0) nbad++;
        prev = pulse;
      end
      if (!ctrl[0]) begin
        tstop = t;
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (R4 no stop): actual %0d expected %0d", 200000, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int ntog, nbad, tf, ts;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    chk(ctrl == 4'h0, "R10 reset ctrl", ctrl, 0);
    chk(pulse == 1'b0 && irq == 1'b0, "R10 reset outputs", {pulse, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    wr(3'd2, 8'h34); wr(3'd3, 8'h12);
    chk(cnt == 16'h1234, "R1 count byte writes", cnt, 16'h1234);

    for (int v = 0; v < NV; v++) begin
      vec_t e;
      e = VEC[v];
      setup(e.per, e.num, e.lvl);
      wr(3'd4, {6'd0, e.ien, 1'b0});
      chk(pulse == e.lvl, "R8 preset level", pulse, e.lvl);
      wr(3'd4, {5'd0, 1'b1, e.ien, 1'b1});  // pend written 1: no effect
      chk(ctrl[2] == 1'b0, "R9 pend write 1 ignored", ctrl[2], 0);
      observe(e.per, ntog, nbad, tf, ts);
      chk(nbad == 0, "R2 flip spacing", nbad, 0);
      chk(tf == e.per + 1, "R7 first flip", tf, e.per + 1);
      chk(ntog == 2 * (e.num + 1), "R3 flip count", ntog, 2 * (e.num + 1));
      chk(ts == 2 * (e.per + 1) * (e.num + 1), "R4 stop edge", ts, 2 * (e.per + 1) * (e.num + 1));
      chk(cnt == 16'hFFFF && ctrl[2], "R4 wrap and pend", cnt, 16'hFFFF);
      chk(irq == e.ien, "R5 irq gating", irq, e.ien);
      chk(pulse == e.lvl, "R8 rest level", pulse, e.lvl);
    end

    // stop during the high half, then restart
    wr(3'd4, 8'h00);
    setup(2, 5, 1'b0);
    wr(3'd4, 8'h01);
    for (int k = 0; k < 20 && pulse == 1'b0; k++) @(negedge clk);
    wr(3'd4, 8'h00);
    held = cnt;
    repeat (20) @(negedge clk);
    chk(cnt == held, "R6 count frozen", cnt, held);
    chk(pulse == 1'b1, "R8 stopped at opposite level", pulse, 1);
    wr(3'd4, 8'h01);
    @(negedge clk); @(negedge clk);
    chk(pulse == 1'b1, "R7 no early flip", pulse, 1);
    @(negedge clk);
    chk(pulse == 1'b0, "R7 full first pulse", pulse, 0);
    wr(3'd4, 8'h00);

    // software stop lands on the underflow edge
    setup(0, 0, 1'b0);
    wr(3'd4, 8'h01);
    @(negedge clk);
    wr(3'd4, 8'h00);
    chk(ctrl[2] == 1'b1, "R11 pend kept on coincident stop", ctrl[2], 1);
    chk(ctrl[0] == 1'b0, "R11 run clear", ctrl[0], 0);
    wr(3'd4, 8'h04);
    chk(ctrl[2] == 1'b1, "R9 write 1 keeps pend", ctrl[2], 1);
    wr(3'd4, 8'h00);
    chk(ctrl[2] == 1'b0, "R9 write 0 clears pend", ctrl[2], 0);

    // reset mid-run keeps period and count
    setup(1, 1, 1'b0);
    wr(3'd4, 8'h0A);
    chk(ctrl == 4'hA, "R9 ien and test bits", ctrl, 4'hA);
    wr(3'd4, 8'h0B);
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl == 4'h0 && irq == 1'b0 && pulse == 1'b0, "R10 reset clears", {ctrl, irq, pulse}, 0);
    repeat (5) @(negedge clk);
    chk(cnt == 16'd1, "R10 count kept", cnt, 1);
    wr(3'd4, 8'h01);
    observe(1, ntog, nbad, tf, ts);
    chk(tf == 2 && ts == 8, "R10 period kept", ts, 8);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule